// File: doc/BRIEF.md
# Flash Program and Erase Sequencer

This block sits on the host side of an asynchronous, byte-wide flash bus and carries out one of three write-type operations for each request: program one byte, erase the block that holds an address, or erase the whole chip. A request arrives on a valid/ready handshake with an operation code, an address and a data byte. The block then issues the unlock and command write cycles with we/oe/ce strobes timed in clock cycles, and polls the device with full read cycles until the operation ends.

Completion is found by reading bit 6 of the returned byte twice in a row: equal values mean the device has finished. When a read that still toggles also shows bit 5 set, two more reads are made. The operation is reported as failed only if bit 6 still differs between those two. A poll limit turns a device that never settles into a timeout. After a failure or timeout, a reset command byte is written before the response so that the device leaves the error state. The response carries a status code and the request address, which names the block to retire when the status is an error.

Top module: `flash_pe_seq`

## Requirements
- R1: `req_ready` is high only when the block is idle, and then all three strobes are high. A request is taken when `req_valid` and `req_ready` are both high. Each request gets exactly one response, whose `rsp_addr` equals the request address.
- R2: Operation code 0 (program) issues four writes in this order: AAh to 5555h, 55h to 2AAAh, A0h to 5555h, then the request data to the request address.
- R3: Code 1 (block erase) issues six writes: AAh to 5555h, 55h to 2AAAh, 80h to 5555h, AAh to 5555h, 55h to 2AAAh, then 30h to the request address. Codes 2 and 3 (chip erase) issue the same first five writes, then 10h to 5555h.
- R4: Each write holds `flash_we_n` low for exactly WR_LOW cycles. `flash_dq_oe` is high for one setup cycle, through the strobe, and for WR_HIGH cycles after it. `flash_we_n` and `flash_oe_n` are never low together.
- R5: Each read holds `flash_oe_n` low for exactly RD_LOW cycles and samples at the end of that time. Before `flash_oe_n` falls, `flash_dq_oe` has been low and `flash_oe_n` high for at least TURN cycles. `flash_dq_oe` is never high while `flash_oe_n` is low.
- R6: After the command writes, the block makes a first read and then compare reads. If a compare read shows the same bit 6 as the read before it, the response status is 0 (done).
- R7: If a compare read differs from the read before it in bit 6 and shows bit 5 = 1, two more reads follow. The status is 1 (error) if their bit 6 values differ, and 0 otherwise.
- R8: If MAX_POLLS compare reads all differ in bit 6 and none shows bit 5 = 1, the status is 2 (timeout).
- R9: For status 1 or 2, one write of F0h to address 0 comes after the last read and before the response. For status 0, no write follows the reads.
- R10: `rsp_valid` is high for exactly one cycle per response.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| req_valid | input | 1 | Request present |
| req_ready | output | 1 | Block idle, ready to take a request |
| req_op | input | 2 | 0 program, 1 block erase, 2 or 3 chip erase |
| req_addr | input | ADDR_W | Target byte or block address |
| req_data | input | 8 | Byte to program |
| rsp_valid | output | 1 | Response strobe, one cycle |
| rsp_status | output | 2 | 0 done, 1 error, 2 timeout |
| rsp_addr | output | ADDR_W | Address of the finished request |
| flash_addr | output | ADDR_W | Flash address bus |
| flash_dq_out | output | 8 | Write data to the flash |
| flash_dq_oe | output | 1 | Host drives the data bus |
| flash_dq_in | input | 8 | Read data from the flash |
| flash_ce_n | output | 1 | Chip enable, active low |
| flash_we_n | output | 1 | Write strobe, active low |
| flash_oe_n | output | 1 | Output enable, active low |

## Verification
The assertions assume that every timing parameter is at least 1 and that TURN stays below 255, so the idle-time counter in the checker does not saturate before the check. They also assume the flash model puts its byte on `flash_dq_in` when `flash_oe_n` falls and holds it until the next fall. The bench model does exactly this. The random stimulus uses only the three device behaviours the status rules cover: settle after B toggling reads, keep toggling with bit 5 set from read E on, or show bit 5 once on the last toggling read and then settle. B and E are kept within a range that reaches both sides of the MAX_POLLS limit. A hard-error case never has bit 5 on the first read.

// File: rtl/flash_seq_pkg.sv
package flash_seq_pkg;

  typedef enum logic [1:0] {
    STAT_DONE    = 2'd0,
    STAT_ERROR   = 2'd1,
    STAT_TIMEOUT = 2'd2
  } stat_e;

  localparam logic [15:0] UNLK_A0 = 16'h5555;
  localparam logic [15:0] UNLK_A1 = 16'h2AAA;
  localparam logic [7:0]  CLR_BYTE = 8'hF0;

  function automatic logic [2:0] seq_len(input logic [1:0] op);
    return (op == 2'd0) ? 3'd4 : 3'd6;
  endfunction

  function automatic logic seq_uses_req_addr(input logic [1:0] op, input logic [2:0] idx);
    return ((op == 2'd0) && (idx == 3'd3)) || ((op == 2'd1) && (idx == 3'd5));
  endfunction

  function automatic logic [15:0] seq_fixed_addr(input logic [2:0] idx);
    return ((idx == 3'd1) || (idx == 3'd4)) ? UNLK_A1 : UNLK_A0;
  endfunction

  function automatic logic [7:0] seq_byte(input logic [1:0] op, input logic [2:0] idx,
                                          input logic [7:0] wdata);
    logic [7:0] b;
    case (idx)
      3'd0:    b = 8'hAA;
      3'd1:    b = 8'h55;
      3'd2:    b = (op == 2'd0) ? 8'hA0 : 8'h80;
      3'd3:    b = (op == 2'd0) ? wdata : 8'hAA;
      3'd4:    b = 8'h55;
      default: b = (op == 2'd1) ? 8'h30 : 8'h10;
    endcase
    return b;
  endfunction

  function automatic int unsigned max4(input int unsigned a, input int unsigned b,
                                       input int unsigned c, input int unsigned d);
    int unsigned m;
    m = a;
    if (b > m) m = b;
    if (c > m) m = c;
    if (d > m) m = d;
    return m;
  endfunction

endpackage

// File: rtl/flash_cmd_gen.sv
module flash_cmd_gen
  import flash_seq_pkg::*;
#(
  parameter int ADDR_W = 19
) (
  input  logic [1:0]        op,
  input  logic [2:0]        idx,
  input  logic [ADDR_W-1:0] req_addr,
  input  logic [7:0]        req_data,
  output logic [ADDR_W-1:0] wr_addr,
  output logic [7:0]        wr_byte,
  output logic              last
);
  localparam int FIX_W = (ADDR_W < 16) ? ADDR_W : 16;

  logic [15:0] fixed_a;

  assign fixed_a = seq_fixed_addr(idx);

  generate
    if (ADDR_W > 16) begin : g_wide
      assign wr_addr = seq_uses_req_addr(op, idx) ? req_addr
                                                  : {{(ADDR_W-16){1'b0}}, fixed_a};
    end else begin : g_narrow
      assign wr_addr = seq_uses_req_addr(op, idx) ? req_addr : fixed_a[FIX_W-1:0];
    end
  endgenerate

  assign wr_byte = seq_byte(op, idx, req_data);
  assign last    = (idx == seq_len(op) - 3'd1);
endmodule

// File: rtl/flash_bus_cycle.sv
module flash_bus_cycle
  import flash_seq_pkg::*;
#(
  parameter int ADDR_W  = 19,
  parameter int WR_LOW  = 4,
  parameter int WR_HIGH = 2,
  parameter int RD_LOW  = 5,
  parameter int TURN    = 3
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              start,
  input  logic              is_write,
  input  logic [ADDR_W-1:0] addr,
  input  logic [7:0]        wdata,
  output logic              done,
  output logic [1:0]        rd_flags,
  output logic [ADDR_W-1:0] flash_addr,
  output logic [7:0]        flash_dq_out,
  output logic              flash_dq_oe,
  input  logic [7:0]        flash_dq_in,
  output logic              flash_ce_n,
  output logic              flash_we_n,
  output logic              flash_oe_n
);
  localparam int MAXC  = max4(WR_LOW, WR_HIGH, RD_LOW, TURN);
  localparam int CNT_W = $clog2(MAXC + 1);

  typedef enum logic [2:0] {
    B_IDLE, B_WSETUP, B_WSTROBE, B_WRECOV, B_RGAP, B_RSTROBE, B_RFLOAT
  } bphase_e;

  bphase_e          ph;
  logic [CNT_W-1:0] cnt;
  logic             cnt_zero;

  assign cnt_zero = (cnt == '0);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ph           <= B_IDLE;
      cnt          <= '0;
      flash_addr   <= '0;
      flash_dq_out <= '0;
      rd_flags     <= '0;
    end else begin
      case (ph)
        B_IDLE: if (start) begin
          flash_addr   <= addr;
          flash_dq_out <= wdata;
          if (is_write) begin
            ph  <= B_WSETUP;
            cnt <= '0;
          end else begin
            ph  <= B_RGAP;
            cnt <= CNT_W'(TURN - 1);
          end
        end
        B_WSETUP: begin
          ph  <= B_WSTROBE;
          cnt <= CNT_W'(WR_LOW - 1);
        end
        B_WSTROBE: if (cnt_zero) begin
          ph  <= B_WRECOV;
          cnt <= CNT_W'(WR_HIGH - 1);
        end else cnt <= cnt - 1'b1;
        B_WRECOV: if (cnt_zero) ph <= B_IDLE;
                  else cnt <= cnt - 1'b1;
        B_RGAP: if (cnt_zero) begin
          ph  <= B_RSTROBE;
          cnt <= CNT_W'(RD_LOW - 1);
        end else cnt <= cnt - 1'b1;
        B_RSTROBE: if (cnt_zero) begin
          rd_flags <= flash_dq_in[6:5];
          ph       <= B_RFLOAT;
          cnt      <= CNT_W'(TURN - 1);
        end else cnt <= cnt - 1'b1;
        B_RFLOAT: if (cnt_zero) ph <= B_IDLE;
                  else cnt <= cnt - 1'b1;
        default: ph <= B_IDLE;
      endcase
    end
  end

  assign done        = ((ph == B_WRECOV) || (ph == B_RFLOAT)) && cnt_zero;
  assign flash_we_n  = (ph != B_WSTROBE);
  assign flash_oe_n  = (ph != B_RSTROBE);
  assign flash_ce_n  = (ph == B_IDLE);
  assign flash_dq_oe = (ph == B_WSETUP) || (ph == B_WSTROBE) || (ph == B_WRECOV);
endmodule

// File: rtl/flash_pe_seq.sv
module flash_pe_seq
  import flash_seq_pkg::*;
#(
  parameter int ADDR_W    = 19,
  parameter int WR_LOW    = 4,
  parameter int WR_HIGH   = 2,
  parameter int RD_LOW    = 5,
  parameter int TURN      = 3,
  parameter int MAX_POLLS = 1024
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              req_valid,
  output logic              req_ready,
  input  logic [1:0]        req_op,
  input  logic [ADDR_W-1:0] req_addr,
  input  logic [7:0]        req_data,
  output logic              rsp_valid,
  output logic [1:0]        rsp_status,
  output logic [ADDR_W-1:0] rsp_addr,
  output logic [ADDR_W-1:0] flash_addr,
  output logic [7:0]        flash_dq_out,
  output logic              flash_dq_oe,
  input  logic [7:0]        flash_dq_in,
  output logic              flash_ce_n,
  output logic              flash_we_n,
  output logic              flash_oe_n
);
  localparam int POLL_W = $clog2(MAX_POLLS + 1);

  typedef enum logic [2:0] {
    S_IDLE, S_CMD, S_POLL0, S_POLL, S_CONF1, S_CONF2, S_CLR, S_RESP
  } sstate_e;

  sstate_e           state;
  logic [1:0]        op_q;
  logic [ADDR_W-1:0] addr_q;
  logic [7:0]        data_q;
  logic [2:0]        idx;
  logic              issued;
  logic              prev_dq6;
  logic [POLL_W-1:0] polls;
  stat_e             stat_q;

  logic              cyc_start, cyc_is_wr, cyc_done;
  logic [ADDR_W-1:0] cyc_addr, gen_addr;
  logic [7:0]        cyc_wdata, gen_byte;
  logic              gen_last;
  logic [1:0]        rd_flags;

  logic              rd_dq6, rd_dq5;
  logic              poll_same, poll_fail_hint, poll_limit;

  flash_cmd_gen #(.ADDR_W(ADDR_W)) u_gen (
    .op(op_q), .idx(idx), .req_addr(addr_q), .req_data(data_q),
    .wr_addr(gen_addr), .wr_byte(gen_byte), .last(gen_last)
  );

  flash_bus_cycle #(
    .ADDR_W(ADDR_W), .WR_LOW(WR_LOW), .WR_HIGH(WR_HIGH), .RD_LOW(RD_LOW), .TURN(TURN)
  ) u_bus (
    .clk(clk), .rst_n(rst_n), .start(cyc_start), .is_write(cyc_is_wr),
    .addr(cyc_addr), .wdata(cyc_wdata), .done(cyc_done), .rd_flags(rd_flags),
    .flash_addr(flash_addr), .flash_dq_out(flash_dq_out), .flash_dq_oe(flash_dq_oe),
    .flash_dq_in(flash_dq_in), .flash_ce_n(flash_ce_n), .flash_we_n(flash_we_n),
    .flash_oe_n(flash_oe_n)
  );

  assign rd_dq6         = rd_flags[1];
  assign rd_dq5         = rd_flags[0];
  assign poll_same      = (rd_dq6 == prev_dq6);
  assign poll_fail_hint = !poll_same && rd_dq5;
  assign poll_limit     = (polls == POLL_W'(MAX_POLLS - 1));

  assign cyc_is_wr = (state == S_CMD) || (state == S_CLR);
  assign cyc_start = (state != S_IDLE) && (state != S_RESP) && !issued;
  assign cyc_addr  = (state == S_CMD) ? gen_addr : (state == S_CLR) ? '0 : addr_q;
  assign cyc_wdata = (state == S_CMD) ? gen_byte : CLR_BYTE;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state    <= S_IDLE;
      op_q     <= '0;
      addr_q   <= '0;
      data_q   <= '0;
      idx      <= '0;
      issued   <= 1'b0;
      prev_dq6 <= 1'b0;
      polls    <= '0;
      stat_q   <= STAT_DONE;
    end else begin
      if (cyc_start)     issued <= 1'b1;
      else if (cyc_done) issued <= 1'b0;

      case (state)
        S_IDLE: if (req_valid) begin
          op_q   <= req_op;
          addr_q <= req_addr;
          data_q <= req_data;
          idx    <= '0;
          state  <= S_CMD;
        end
        S_CMD: if (cyc_done) begin
          if (gen_last) state <= S_POLL0;
          else          idx   <= idx + 3'd1;
        end
        S_POLL0: if (cyc_done) begin
          prev_dq6 <= rd_dq6;
          polls    <= '0;
          state    <= S_POLL;
        end
        S_POLL: if (cyc_done) begin
          if (poll_same) begin
            stat_q <= STAT_DONE;
            state  <= S_RESP;
          end else if (poll_fail_hint) begin
            state <= S_CONF1;
          end else if (poll_limit) begin
            stat_q <= STAT_TIMEOUT;
            state  <= S_CLR;
          end else begin
            prev_dq6 <= rd_dq6;
            polls    <= polls + 1'b1;
          end
        end
        S_CONF1: if (cyc_done) begin
          prev_dq6 <= rd_dq6;
          state    <= S_CONF2;
        end
        S_CONF2: if (cyc_done) begin
          if (poll_same) begin
            stat_q <= STAT_DONE;
            state  <= S_RESP;
          end else begin
            stat_q <= STAT_ERROR;
            state  <= S_CLR;
          end
        end
        S_CLR:   if (cyc_done) state <= S_RESP;
        S_RESP:  state <= S_IDLE;
        default: state <= S_IDLE;
      endcase
    end
  end

  assign req_ready  = (state == S_IDLE);
  assign rsp_valid  = (state == S_RESP);
  assign rsp_status = stat_q;
  assign rsp_addr   = addr_q;
endmodule

// File: rtl/flash_pe_seq_chk.sv
module flash_pe_seq_chk #(
  parameter int WR_LOW = 4,
  parameter int RD_LOW = 5,
  parameter int TURN   = 3
) (
  input logic clk,
  input logic rst_n,
  input logic req_ready,
  input logic rsp_valid,
  input logic flash_dq_oe,
  input logic flash_ce_n,
  input logic flash_we_n,
  input logic flash_oe_n
);
  logic [15:0] we_low_cnt, oe_low_cnt;
  logic [7:0]  quiet_cnt;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      we_low_cnt <= '0;
      oe_low_cnt <= '0;
      quiet_cnt  <= '0;
    end else begin
      we_low_cnt <= flash_we_n ? '0 : we_low_cnt + 16'd1;
      oe_low_cnt <= flash_oe_n ? '0 : oe_low_cnt + 16'd1;
      if (!flash_dq_oe && flash_oe_n) quiet_cnt <= (quiet_cnt == 8'hFF) ? quiet_cnt : quiet_cnt + 8'd1;
      else                            quiet_cnt <= '0;
    end
  end

  AST_IDLE_BUS_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
    req_ready |-> (flash_ce_n && flash_we_n && flash_oe_n)); // R1
  AST_WE_PULSE_WIDTH: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(flash_we_n) |-> (we_low_cnt == 16'(WR_LOW))); // R4
  AST_NO_STROBE_OVERLAP: assert property (@(posedge clk) disable iff (!rst_n)
    !(!flash_we_n && !flash_oe_n)); // R4
  AST_NO_DRIVE_IN_READ: assert property (@(posedge clk) disable iff (!rst_n)
    !flash_oe_n |-> !flash_dq_oe); // R5
  AST_RELEASE_BEFORE_READ: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(flash_oe_n) |-> (quiet_cnt >= 8'(TURN))); // R5
  AST_OE_PULSE_WIDTH: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(flash_oe_n) |-> (oe_low_cnt == 16'(RD_LOW))); // R5
  AST_RSP_SINGLE: assert property (@(posedge clk) disable iff (!rst_n)
    rsp_valid |=> !rsp_valid); // R10
endmodule

bind flash_pe_seq flash_pe_seq_chk #(.WR_LOW(WR_LOW), .RD_LOW(RD_LOW), .TURN(TURN)) u_chk (
  .clk(clk), .rst_n(rst_n), .req_ready(req_ready), .rsp_valid(rsp_valid),
  .flash_dq_oe(flash_dq_oe), .flash_ce_n(flash_ce_n), .flash_we_n(flash_we_n),
  .flash_oe_n(flash_oe_n)
);

// File: tb/flash_pe_seq_tb.sv
module flash_pe_seq_tb;
  localparam int AW = 19;
  localparam int WRL = 3, WRH = 2, RDL = 4, TRN = 2, MAXP = 16;

  logic clk = 1'b0, rst_n = 1'b0;
  logic req_valid = 1'b0, req_ready;
  logic [1:0] req_op = '0;
  logic [AW-1:0] req_addr = '0;
  logic [7:0] req_data = '0;
  logic rsp_valid;
  logic [1:0] rsp_status;
  logic [AW-1:0] rsp_addr, flash_addr;
  logic [7:0] flash_dq_out;
  logic [7:0] flash_dq_in = '0;
  logic flash_dq_oe, flash_ce_n, flash_we_n, flash_oe_n;

  int n_chk = 0, n_bad = 0;

  always #5 clk = ~clk;

  flash_pe_seq #(.ADDR_W(AW), .WR_LOW(WRL), .WR_HIGH(WRH), .RD_LOW(RDL), .TURN(TRN),
                 .MAX_POLLS(MAXP)) u_dut (.*);

  // device model: mode 0 settles after m_b toggling reads, 1 hard error from read m_e,
  // 2 bit 5 shown on the last toggling read then settles
  int m_mode, m_b, m_e, m_wr_n, m_rd_n, m_clr_n, m_exp_len;
  logic m_busy = 1'b0, m_tog = 1'b0;
  logic [AW-1:0] m_wa [8];
  logic [7:0] m_wd [8];

  always @(posedge flash_we_n) begin
    if (rst_n && flash_dq_oe === 1'b1) begin
      if (m_wr_n >= m_exp_len) begin
        if (flash_dq_out == 8'hF0 && flash_addr == '0) m_clr_n++;
        m_busy = 1'b0;
      end else begin
        m_wa[m_wr_n] = flash_addr;
        m_wd[m_wr_n] = flash_dq_out;
        m_wr_n++;
        if (m_wr_n == m_exp_len) begin
          m_busy = 1'b1;
          m_rd_n = 0;
        end
      end
    end
  end

  always @(negedge flash_oe_n) begin
    logic d5;
    d5 = 1'b0;
    if (rst_n) begin
      m_rd_n++;
      if (m_busy) begin
        if (m_mode == 1) begin
          m_tog = ~m_tog;
          d5 = (m_rd_n >= m_e);
        end else if (m_rd_n <= m_b) begin
          m_tog = ~m_tog;
          d5 = (m_mode == 2) && (m_rd_n == m_b);
        end
      end
      flash_dq_in = {1'b1, m_tog, d5, 5'b10101};
    end
  end

  // bus timing monitor
  int wl = 0, ol = 0, quiet = 0, bad_w = 0, bad_r = 0, bad_gap = 0, bad_ovl = 0;
  logic pwe = 1'b1, poe = 1'b1;
  always @(posedge clk) if (rst_n) begin
    if (!flash_we_n && !flash_oe_n) bad_ovl++;
    if (!flash_oe_n && flash_dq_oe) bad_ovl++;
    if (flash_we_n && !pwe && wl != WRL) bad_w++;
    if (flash_oe_n && !poe && ol != RDL) bad_r++;
    if (!flash_oe_n && poe && quiet < TRN) bad_gap++;
    wl = flash_we_n ? 0 : wl + 1;
    ol = flash_oe_n ? 0 : ol + 1;
    quiet = (!flash_dq_oe && flash_oe_n) ? quiet + 1 : 0;
    pwe = flash_we_n;
    poe = flash_oe_n;
  end

  task automatic check(input bit ok, input string req, input string what,
                       input longint act, input longint exp);
    n_chk++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
    end
  endtask

  function automatic logic [AW+7:0] exp_write(input int op, input int i,
                                              input logic [AW-1:0] a, input logic [7:0] d);
    logic [AW-1:0] ea;
    logic [7:0] ed;
    ea = (i == 1 || i == 4) ? AW'(16'h2AAA) : AW'(16'h5555);
    case (i)
      0: ed = 8'hAA;
      1: ed = 8'h55;
      2: ed = (op == 0) ? 8'hA0 : 8'h80;
      3: begin ed = (op == 0) ? d : 8'hAA; if (op == 0) ea = a; end
      4: ed = 8'h55;
      default: begin ed = (op == 1) ? 8'h30 : 8'h10; if (op == 1) ea = a; end
    endcase
    return {ea, ed};
  endfunction

  function automatic int exp_status(input int mode, input int b, input int e);
    int need;
    if (mode == 1) return (e - 1 <= MAXP) ? 1 : 2;
    if (mode == 2) return (b - 1 <= MAXP) ? 0 : 2;
    need = (b < 1) ? 1 : b;
    return (need <= MAXP) ? 0 : 2;
  endfunction

  int waited;
  bit wd_fail = 0;

  task automatic run_txn(input int op, input logic [AW-1:0] a, input logic [7:0] d,
                         input int mode, input int b, input int e);
    int es, len;
    bit seq_ok;
    string rq;
    es = exp_status(mode, b, e);
    len = (op == 0) ? 4 : 6;
    m_mode = mode; m_b = b; m_e = e; m_wr_n = 0; m_rd_n = 0; m_clr_n = 0; m_exp_len = len;
    @(negedge clk);
    waited = 0;
    while (!req_ready && waited < 20000) begin @(negedge clk); waited++; end
    req_valid = 1'b1; req_op = 2'(op); req_addr = a; req_data = d;
    @(negedge clk);
    req_valid = 1'b0;
    check(req_ready == 1'b0, "R1", "ready dropped while busy", req_ready, 0);
    waited = 0;
    while (!rsp_valid && waited < 20000) begin @(negedge clk); waited++; end
    if (!rsp_valid) begin
      wd_fail = 1;
      check(0, "R1", "watchdog: no response", 0, 1);
      return;
    end
    check(rsp_addr == a, "R1", "response address", rsp_addr, a);
    rq = (es == 2) ? "R8" : (mode == 0) ? "R6" : "R7";
    check(rsp_status == 2'(es), rq, "status", rsp_status, es);
    seq_ok = (m_wr_n == len);
    for (int i = 0; i < len; i++)
      if (i < m_wr_n && {m_wa[i], m_wd[i]} != exp_write(op, i, a, d)) seq_ok = 0;
    check(seq_ok, (op == 0) ? "R2" : "R3", "command write sequence", m_wr_n, len);
    check(m_clr_n == ((es != 0) ? 1 : 0), "R9", "reset writes", m_clr_n, (es != 0) ? 1 : 0);
    @(negedge clk);
    check(rsp_valid == 1'b0, "R10", "response one cycle", rsp_valid, 0);
  endtask

  initial begin
    int seed, op, mode, b, e;
    seed = $urandom(32'h5EED_0042);
    repeat (3) @(negedge clk);
    check(req_ready && flash_we_n && flash_oe_n && flash_ce_n && !flash_dq_oe && !rsp_valid,
          "R1", "reset state", {req_ready, flash_we_n, flash_oe_n, flash_ce_n, flash_dq_oe, rsp_valid},
          6'b111100);
    rst_n = 1'b1;
    // directed corner cases
    run_txn(0, 19'h12345, 8'h5A, 0, 0, 0);       // R6 immediate completion
    run_txn(0, 19'h00001, 8'hF0, 0, MAXP, 0);    // R6 at the poll limit
    run_txn(1, 19'h40000, 8'h00, 0, MAXP + 1, 0); // R8 one past the limit
    run_txn(2, 19'h7FFFF, 8'h00, 1, 0, 3);       // R7 hard error
    run_txn(1, 19'h10000, 8'h00, 1, 0, MAXP + 2); // R8 error seen too late
    run_txn(0, 19'h2AAAA, 8'h33, 2, 2, 0);       // R7 bit 5 not confirmed
    run_txn(3, 19'h05555, 8'h00, 2, MAXP + 1, 0); // R3 code 3, R7 at the limit
    for (int k = 0; k < 20 && !wd_fail; k++) begin
      op = $urandom % 4;
      mode = $urandom % 3;
      b = $urandom % 21;
      e = 2 + $urandom % 19;
      if (mode == 2 && b < 2) b = 2;
      run_txn(op, AW'($urandom), 8'($urandom), mode, b, e);
    end
    check(bad_w == 0 && bad_ovl == 0, "R4", "write strobe width and overlap", bad_w + bad_ovl, 0);
    check(bad_r == 0 && bad_gap == 0, "R5", "read strobe width and turnaround", bad_r + bad_gap, 0);
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end

  initial begin
    #1900000;
    n_chk++; n_bad++;
    $display("FAIL R1 global watchdog: actual 0 expected 1");
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end
endmodule